// File: doc/BRIEF.md
# Fetch-Stage Branch Outcome and Target Predictor

This block sits beside the instruction fetch address. Each cycle it looks up the current fetch address in a direct-mapped table and returns a guess of whether the instruction there is a taken branch, together with the next fetch address: the cached target when the guess is taken, or the sequential address (fetch address plus 4) otherwise. Because the target is cached next to the outcome state, a taken guess needs no stall.

When a branch resolves later in the pipeline, the resolving address, its real outcome, its real target and a misprediction flag come back on the resolution port. The entry selected by that address is trained, and on a misprediction the block raises a redirect carrying the correct restart address so that the pipeline can drop the wrong-path instructions. A parameter selects either a one-bit last-outcome state or a two-bit saturating counter per entry. Entries are selected by low address bits only, so unrelated branches may share an entry; this affects accuracy, never correctness.

Top module: `bpred_top`

## Requirements
- R1: After reset every entry predicts not-taken, and the predicted next address equals fetch address plus 4.
- R2: The entry is selected by fetch address bits [log2(DEPTH)+1:2]; two addresses that differ by DEPTH*4 share one entry, including its state and target.
- R3: With CTR_W=2 each entry holds a counter 0..3 that a taken resolution raises and a not-taken resolution lowers, saturating at 3 and 0; the entry predicts taken when the counter is 2 or 3, so two wrong guesses in a row are needed to flip the guess.
- R4: With CTR_W=1 each entry holds one bit equal to the last resolved outcome (1 = taken), which inverts the guess on each misprediction; it resets to not-taken.
- R5: A taken resolution stores its target in the entry and marks the target valid; a taken guess returns that stored target as the next address.
- R6: An entry without a valid target predicts not-taken and returns fetch address plus 4.
- R7: When a resolution is valid and flagged as mispredicted, redirect is high in that same cycle with the restart address equal to the real target if taken, or resolving address plus 4 if not taken; otherwise redirect is low.
- R8: When a lookup and a resolution select the same entry in one cycle, the lookup returns the entry's value before the update; the update is visible from the next cycle.
- R9: For a loop branch taken nine times then not taken once, repeated, steady state gives one misprediction per loop run with CTR_W=2 and two with CTR_W=1.
- R10: Resolution fields presented while the resolution valid input is low change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | AW | Current fetch address to look up |
| pred_taken | output | 1 | Guess that the fetched instruction is a taken branch |
| pred_next_pc | output | AW | Predicted next fetch address |
| res_valid | input | 1 | A branch resolution is present this cycle |
| res_pc | input | AW | Address of the resolving branch |
| res_taken | input | 1 | Real outcome of the resolving branch |
| res_target | input | AW | Real target of the resolving branch |
| res_mispredict | input | 1 | The earlier guess for this branch was wrong |
| redirect_valid | output | 1 | Flush wrong-path work and restart fetch |
| redirect_pc | output | AW | Address at which fetch restarts |

## Verification
The hardest situation to reach from the ports is a lookup and a training update hitting the same entry in one cycle, and the closely related case of two different addresses aliasing onto one entry. The stimulus reaches both on purpose: a directed step presents the same address on lookup and resolution in one cycle, another trains one address and looks up its alias DEPTH*4 higher, and the random phase draws fetch and resolution addresses from a small pool that includes aliases so that such collisions recur throughout. Two instances, one per state width, share every stimulus so the hysteresis difference shows up in the loop-branch run.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef logic [1:0] ctr_t;

  function automatic ctr_t ctr_max(input int unsigned w);
    return (w == 1) ? 2'd1 : 2'd3;
  endfunction

  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken, input int unsigned w);
    ctr_t top;
    top = ctr_max(w);
    if (taken) return (cur >= top) ? top : cur + 2'd1;
    return (cur == 2'd0) ? 2'd0 : cur - 2'd1;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t cur, input int unsigned w);
    return (w == 1) ? cur[0] : cur[1];
  endfunction

endpackage

// File: rtl/bpred_table.sv
module bpred_table #(
  parameter int DEPTH = 4096,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     rd_idx,
  output bpred_pkg::ctr_t   rd_ctr,
  output logic              rd_valid,
  output logic [AW-1:0]     rd_tgt,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  bpred_pkg::ctr_t   wr_ctr,
  input  logic              wr_set_tgt,
  input  logic [AW-1:0]     wr_tgt,
  output bpred_pkg::ctr_t   wr_old_ctr
);
  import bpred_pkg::*;

  ctr_t              ctr_mem [DEPTH];
  logic [DEPTH-1:0]  tgt_ok;
  logic [AW-1:0]     tgt_mem [DEPTH];

  // state and valid: reset so every entry starts not-taken with no target
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_mem[i] <= '0;
      tgt_ok <= '0;
    end else if (wr_en) begin
      ctr_mem[wr_idx] <= wr_ctr;
      if (wr_set_tgt) tgt_ok[wr_idx] <= 1'b1;
    end
  end

  // target payload: guarded by tgt_ok, needs no reset
  always_ff @(posedge clk) begin
    if (wr_en && wr_set_tgt) tgt_mem[wr_idx] <= wr_tgt;
  end

  // reads are combinational and see the pre-update contents (R8)
  assign rd_ctr     = ctr_mem[rd_idx];
  assign rd_valid   = tgt_ok[rd_idx];
  assign rd_tgt     = tgt_mem[rd_idx];
  assign wr_old_ctr = ctr_mem[wr_idx];

  assert_tgt_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_set_tgt) |=> (tgt_ok[$past(wr_idx)] && tgt_mem[$past(wr_idx)] == $past(wr_tgt)));

  assert_no_write_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (ctr_mem[$past(rd_idx)] == $past(rd_ctr) && tgt_ok[$past(rd_idx)] == $past(rd_valid)));

  assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> tgt_ok[$past(rd_idx)]);

endmodule

// File: rtl/bpred_update.sv
module bpred_update #(
  parameter int CTR_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            taken,
  input  bpred_pkg::ctr_t old_ctr,
  output bpred_pkg::ctr_t new_ctr
);
  import bpred_pkg::*;

  generate
    if (CTR_W == 1) begin : g_one_bit
      // single bit follows the last outcome
      always_comb new_ctr = ctr_next(old_ctr, taken, 1);
    end else begin : g_two_bit
      always_comb new_ctr = ctr_next(old_ctr, taken, 2);
    end
  endgenerate

  assert_ctr_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && taken) |-> (new_ctr >= old_ctr));

  assert_ctr_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !taken) |-> (new_ctr <= old_ctr));

  assert_ctr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (new_ctr <= ctr_max(CTR_W)));

  assert_hysteresis_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && CTR_W == 2 && old_ctr == 2'd3 && !taken) |-> ctr_says_taken(new_ctr, 2));

  assert_one_bit_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && CTR_W == 1) |-> (new_ctr == {1'b0, taken}));

endmodule

// File: rtl/bpred_redirect.sv
module bpred_redirect #(
  parameter int AW = 32
) (
  input  logic          res_valid,
  input  logic          res_taken,
  input  logic          res_mispredict,
  input  logic [AW-1:0] res_pc,
  input  logic [AW-1:0] res_target,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc
);
  always_comb begin
    redirect_valid = res_valid && res_mispredict;
    redirect_pc    = res_taken ? res_target : res_pc + AW'(4);
  end
endmodule

// File: rtl/bpred_top.sv
module bpred_top #(
  parameter int DEPTH = 4096,
  parameter int AW    = 32,
  parameter int CTR_W = 2,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetch_pc,
  output logic          pred_taken,
  output logic [AW-1:0] pred_next_pc,
  input  logic          res_valid,
  input  logic [AW-1:0] res_pc,
  input  logic          res_taken,
  input  logic [AW-1:0] res_target,
  input  logic          res_mispredict,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc
);
  import bpred_pkg::*;

  // word-aligned index: drop the two byte-offset bits
  function automatic logic [IW-1:0] pc_to_index(input logic [AW-1:0] pc);
    return IW'(pc >> 2);
  endfunction

  function automatic logic [AW-1:0] seq_pc(input logic [AW-1:0] pc);
    return pc + AW'(4);
  endfunction

  logic [IW-1:0] look_idx, train_idx;
  ctr_t          look_ctr, train_old, train_new;
  logic          look_tgt_ok;
  logic [AW-1:0] look_tgt;
  logic          look_says_taken;

  assign look_idx  = pc_to_index(fetch_pc);
  assign train_idx = pc_to_index(res_pc);

  bpred_table #(.DEPTH(DEPTH), .AW(AW)) table_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (look_idx),
    .rd_ctr     (look_ctr),
    .rd_valid   (look_tgt_ok),
    .rd_tgt     (look_tgt),
    .wr_en      (res_valid),
    .wr_idx     (train_idx),
    .wr_ctr     (train_new),
    .wr_set_tgt (res_taken),
    .wr_tgt     (res_target),
    .wr_old_ctr (train_old)
  );

  bpred_update #(.CTR_W(CTR_W)) update_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (res_valid),
    .taken   (res_taken),
    .old_ctr (train_old),
    .new_ctr (train_new)
  );

  bpred_redirect #(.AW(AW)) redirect_i (
    .res_valid      (res_valid),
    .res_taken      (res_taken),
    .res_mispredict (res_mispredict),
    .res_pc         (res_pc),
    .res_target     (res_target),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
  );

  assign look_says_taken = ctr_says_taken(look_ctr, CTR_W);

  // no usable target means fall through (R6)
  always_comb begin
    pred_taken   = look_tgt_ok && look_says_taken;
    pred_next_pc = pred_taken ? look_tgt : seq_pc(fetch_pc);
  end

  assert_no_target_not_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !look_tgt_ok |-> (!pred_taken && pred_next_pc == fetch_pc + AW'(4)));

  assert_taken_uses_cache_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> (pred_next_pc == look_tgt));

  assert_redirect_fallthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !res_taken) |-> (redirect_pc == res_pc + AW'(4)));

  assert_redirect_needs_resolution_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> res_valid);

endmodule

// File: tb/bpred_top_tb_top.sv
`timescale 1ns/1ps
module bpred_top_tb_top;
  localparam int DEPTH = 4096;
  localparam int AW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          res_valid = 1'b0;
  logic [AW-1:0] res_pc = '0;
  logic          res_taken = 1'b0;
  logic [AW-1:0] res_target = '0;
  logic          res_mispredict = 1'b0;
  logic          p2_taken, p1_taken, rd2_v, rd1_v;
  logic [AW-1:0] p2_next, p1_next, rd2_pc, rd1_pc;

  int checks = 0;
  int fails  = 0;

  // bench model
  int          m2 [DEPTH];
  int          m1 [DEPTH];
  bit          mv [DEPTH];
  logic [AW-1:0] mt [DEPTH];

  always #10 clk = ~clk;

  bpred_top #(.DEPTH(DEPTH), .AW(AW), .CTR_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_taken(p2_taken), .pred_next_pc(p2_next),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_mispredict(res_mispredict),
    .redirect_valid(rd2_v), .redirect_pc(rd2_pc));

  bpred_top #(.DEPTH(DEPTH), .AW(AW), .CTR_W(1)) dut_1b_i (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_taken(p1_taken), .pred_next_pc(p1_next),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_mispredict(res_mispredict),
    .redirect_valid(rd1_v), .redirect_pc(rd1_pc));

  function automatic int idx_of(input logic [AW-1:0] pc);
    return int'((pc / 4) % DEPTH);
  endfunction

  function automatic bit exp2_taken(input logic [AW-1:0] pc);
    return mv[idx_of(pc)] && (m2[idx_of(pc)] >= 2);
  endfunction

  function automatic bit exp1_taken(input logic [AW-1:0] pc);
    return mv[idx_of(pc)] && (m1[idx_of(pc)] == 1);
  endfunction

  function automatic logic [AW-1:0] exp_next(input logic [AW-1:0] pc, input bit tk);
    return tk ? mt[idx_of(pc)] : pc + 32'd4;
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m2[i] = 0; m1[i] = 0; mv[i] = 1'b0; mt[i] = '0;
    end
  endtask

  task automatic model_train(input logic [AW-1:0] pc, input bit tk, input logic [AW-1:0] tg);
    int k;
    k = idx_of(pc);
    if (tk) begin
      if (m2[k] < 3) m2[k]++;
      m1[k] = 1;
      mv[k] = 1'b1;
      mt[k] = tg;
    end else begin
      if (m2[k] > 0) m2[k]--;
      m1[k] = 0;
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, train model after posedge
  task automatic cycle(input logic [AW-1:0] fpc, input bit rv, input logic [AW-1:0] rpc,
                       input bit rtk, input logic [AW-1:0] rtg, input bit rmis);
    bit e2, e1;
    @(negedge clk);
    fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rtk;
    res_target = rtg; res_mispredict = rmis;
    #2;
    e2 = exp2_taken(fpc);
    e1 = exp1_taken(fpc);
    check("R3 two-bit guess", {31'd0, p2_taken}, {31'd0, e2});
    check("R5 two-bit next pc", p2_next, exp_next(fpc, e2));
    check("R4 one-bit guess", {31'd0, p1_taken}, {31'd0, e1});
    check("R5 one-bit next pc", p1_next, exp_next(fpc, e1));
    check("R7 redirect valid", {31'd0, rd2_v}, {31'd0, rv && rmis});
    if (rv && rmis)
      check("R7 redirect pc", rd2_pc, rtk ? rtg : rpc + 32'd4);
    @(posedge clk);
    #1;
    if (rv) model_train(rpc, rtk, rtg);
  endtask

  task automatic idle_look(input logic [AW-1:0] fpc);
    cycle(fpc, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] pa, pt;
    int miss2, miss1;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R6: fresh table predicts fall-through everywhere
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      fetch_pc = 32'h100 + i * 32'h1234;
      #2;
      check("R1 reset guess", {31'd0, p2_taken | p1_taken}, 32'd0);
      check("R1 reset next pc", p2_next, fetch_pc + 32'd4);
    end

    // R6: not-taken-only training leaves no target, so no taken guess
    cycle(32'h300, 1'b1, 32'h300, 1'b0, 32'hdead0000, 1'b0);
    idle_look(32'h300);
    check("R6 no target", {31'd0, p2_taken | p1_taken}, 32'd0);

    // R10: resolution fields ignored without res_valid
    for (int i = 0; i < 3; i++) cycle(32'h400, 1'b0, 32'h400, 1'b1, 32'h9000, 1'b0);
    idle_look(32'h400);
    check("R10 ignored update", {31'd0, p2_taken | p1_taken}, 32'd0);

    // R2: train one address, look up its alias DEPTH*4 higher
    pa = 32'h200; pt = 32'h0000_7000;
    cycle(32'h0, 1'b1, pa, 1'b1, pt, 1'b1);
    cycle(32'h0, 1'b1, pa, 1'b1, pt, 1'b1);
    idle_look(pa + DEPTH * 4);
    check("R2 alias guess", {31'd0, p2_taken}, 32'd1);
    check("R2 alias target", p2_next, pt);

    // R3 hysteresis: saturate, one not-taken keeps guess taken
    cycle(32'h0, 1'b1, pa, 1'b1, pt, 1'b0);
    cycle(32'h0, 1'b1, pa, 1'b0, pt, 1'b1);
    idle_look(pa);
    check("R3 hysteresis keeps taken", {31'd0, p2_taken}, 32'd1);
    check("R4 one-bit flips", {31'd0, p1_taken}, 32'd0);

    // R8: same-cycle lookup and update on one entry returns old value
    cycle(32'h0, 1'b1, pa, 1'b1, pt, 1'b0);
    @(negedge clk);
    fetch_pc = pa; res_valid = 1'b1; res_pc = pa; res_taken = 1'b0;
    res_target = pt; res_mispredict = 1'b1;
    #2;
    check("R8 old value seen", {31'd0, p1_taken}, 32'd1);
    @(posedge clk); #1;
    model_train(pa, 1'b0, pt);
    idle_look(pa);
    check("R8 update visible next cycle", {31'd0, p1_taken}, 32'd0);

    // R9: loop branch, 9 taken then 1 not taken, three runs
    pa = 32'h8000; pt = 32'h7f00;
    for (int run = 0; run < 3; run++) begin
      miss2 = 0; miss1 = 0;
      for (int it = 0; it < 10; it++) begin
        bit act, g2, g1;
        act = (it != 9);
        g2 = exp2_taken(pa);
        g1 = exp1_taken(pa);
        if (g2 != act) miss2++;
        if (g1 != act) miss1++;
        cycle(pa, 1'b1, pa, act, pt, g2 != act);
      end
      if (run > 0) begin
        check("R9 two-bit misses per run", miss2, 32'd1);
        check("R9 one-bit misses per run", miss1, 32'd2);
      end
    end

    // random phase with a small address pool including aliases
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] f, r, t;
      bit tk, rv, g;
      f  = 32'h1000 + ($urandom_range(0, 15) * 4) + ($urandom_range(0, 1) * DEPTH * 4);
      r  = ($urandom_range(0, 3) == 0) ? f
         : 32'h1000 + ($urandom_range(0, 15) * 4) + ($urandom_range(0, 1) * DEPTH * 4);
      t  = 32'h2_0000 + ($urandom_range(0, 255) * 4);
      tk = $urandom_range(0, 2) != 0;
      rv = $urandom_range(0, 3) != 0;
      g  = exp2_taken(r);
      cycle(f, rv, r, tk, t, (g != tk) || (g && mt[idx_of(r)] != t));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule